// File: doc/BRIEF.md
# Legacy display register port

This block is the byte-wide I/O front end of a legacy display controller. A host drives an I/O address with a one-cycle read or write strobe. The block decodes the address and gives access to four indexed register groups: sequencer, graphics, attribute and CRT. Each group is reached by first writing an index and then reading or writing a data port. A few direct registers sit beside the groups: miscellaneous output, feature control and two status ports. Read data is combinational in the strobe cycle. State changes take effect at the clock edge that ends the strobe.

The CRT and status ports appear in two address windows, a monochrome one (0x3B0–0x3BF) and a colour one (0x3D0–0x3DF). Bit 0 of the miscellaneous output register chooses which window is live. The attribute group has no separate data port for writes. A flip-flop decides whether a write to its single port is an index or data. Reading input status 1 resets that flip-flop, which gives software a known starting point. Per-register keep masks force unimplemented bits to zero. A lock bit in the CRT file protects the low timing registers.

Top module: `disp_regport`

## Requirements
- R1: After reset every register reads 0x00, the attribute flip-flop is 0, and CRT entries 0x2D, 0x2E, 0x2F and 0x30 read 0x88, 0xB0, 0x01 and 0xE1.
- R2: With miscellaneous bit 0 set, an access to 0x3B0–0x3BF is ignored and a read there returns 0xFF. With the bit clear, the same holds for 0x3D0–0x3DF.
- R3: Every write to 0x3C0 toggles the attribute flip-flop. With the flip-flop at 0 the write stores the attribute index as wdata[5:0]. With it at 1 the write stores data into the entry selected by index[4:0].
- R4: A read of 0x3C0 returns the attribute index when the flip-flop is 0 and 0x00 when it is 1. A read of 0x3C1 returns the selected entry when index[4:0] < 21 and 0x00 otherwise.
- R5: Attribute data is kept by entry:
  - entries 0–15 keep 0x3F;
  - entry 16 keeps 0xEF;
  - entry 17 keeps 0xFF;
  - entry 18 keeps 0x3F;
  - entries 19 and 20 keep 0x0F;
  - writes to entries 21–31 are dropped.
- R6: The sequencer index (0x3C4) keeps 3 bits and the graphics index (0x3CE) keeps 4 bits. Writes to the data ports 0x3C5 and 0x3CF are ANDed with a keep mask per index:
  - sequencer, indices 0–7: 03 3D 0F 3F 0E 00 00 FF;
  - graphics: indices 0–2 and 6–7 keep 0F, index 3 keeps 1F, index 4 keeps 03, index 5 keeps 7B, index 8 keeps FF, indices 9–15 keep 00.
- R7: While bit 7 of CRT entry 0x11 is set, writes to CRT entries 0–6 are dropped. A write to entry 7 then changes only its bit 4.
- R8: A read of input status 1 (0x3BA or 0x3DA, live window) toggles bits 3 and 0 of the status value. The read returns the toggled value and clears the attribute flip-flop.
- R9: A write to 0x3C2 stores wdata with bit 4 cleared; 0x3CC reads it back. A write to 0x3BA/0x3DA stores only bit 4 into feature control; 0x3CA reads it back. 0x3C2 reads 0x00.
- R10: CRT entries 0x2D–0x30 ignore writes.
- R11: The CRT index (0x3B4/0x3D4) is 8 bits wide and all 256 CRT entries are storage. Unmapped ports inside a live window read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | I/O address |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the strobe cycle |

## Verification
The bench targets the side effects that a register front end most easily gets wrong:
- **Attribute flip-flop phase.** The flip-flop must be reset by a status read and toggled by every 0x3C0 write. A design that missed either would file data as an index, and every later attribute read would drift out of step.
- **Alias windows.** Reads through the dead window must return 0xFF and leave no trace. A design that let such a read through would toggle the status or clear the flip-flop when it should not.
- **CRT lock.** Under the lock, a write to entry 7 must change bit 4 only. Entries 0–6 must not change at all.
- **Masks at the edges of their ranges.** The keep masks are checked at index 16, at index 20, just past 20, and at the top sequencer and graphics indices. There a mask off by one entry shows up as a wrong read-back value.

// File: rtl/disp_regport_pkg.sv
package disp_regport_pkg;

  localparam int ATTR_N = 21;

  typedef enum logic [3:0] {
    PS_NONE, PS_ATTR, PS_ATTR_DAT, PS_MISC_ST0, PS_SEQ_IDX, PS_SEQ_DAT,
    PS_FCR_RD, PS_MISC_RD, PS_GFX_IDX, PS_GFX_DAT, PS_CRT_IDX, PS_CRT_DAT,
    PS_STAT
  } port_sel_e;

  function automatic logic [7:0] seq_keep(input int k);
    case (k)
      0: return 8'h03;
      1: return 8'h3D;
      2: return 8'h0F;
      3: return 8'h3F;
      4: return 8'h0E;
      7: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] gfx_keep(input int k);
    case (k)
      0, 1, 2, 6, 7: return 8'h0F;
      3: return 8'h1F;
      4: return 8'h03;
      5: return 8'h7B;
      8: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] attr_keep(input int k);
    if (k < 16) return 8'h3F;
    case (k)
      16: return 8'hEF;
      17: return 8'hFF;
      18: return 8'h3F;
      default: return 8'h0F;
    endcase
  endfunction

  function automatic logic [7:0] crt_reset(input int k);
    case (k)
      8'h2D: return 8'h88;
      8'h2E: return 8'hB0;
      8'h2F: return 8'h01;
      8'h30: return 8'hE1;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/disp_port_dec.sv
module disp_port_dec
  import disp_regport_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] MONO_BASE   = 16'h03B0,
  parameter logic [ADDR_W-1:0] COLOR_BASE  = 16'h03D0,
  parameter logic [ADDR_W-1:0] SHARED_BASE = 16'h03C0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              color_i,
  output logic              win_bad_o,
  output port_sel_e         sel_o
);
  logic [ADDR_W-5:0] hi;
  logic [3:0]        lo;
  logic              in_sh, in_mo, in_co;

  assign hi    = addr_i[ADDR_W-1:4];
  assign lo    = addr_i[3:0];
  assign in_sh = hi == SHARED_BASE[ADDR_W-1:4];
  assign in_mo = hi == MONO_BASE[ADDR_W-1:4];
  assign in_co = hi == COLOR_BASE[ADDR_W-1:4];
  assign win_bad_o = (in_mo && color_i) || (in_co && !color_i);

  always_comb begin
    sel_o = PS_NONE;
    if (in_sh) begin
      case (lo)
        4'h0: sel_o = PS_ATTR;
        4'h1: sel_o = PS_ATTR_DAT;
        4'h2: sel_o = PS_MISC_ST0;
        4'h4: sel_o = PS_SEQ_IDX;
        4'h5: sel_o = PS_SEQ_DAT;
        4'hA: sel_o = PS_FCR_RD;
        4'hC: sel_o = PS_MISC_RD;
        4'hE: sel_o = PS_GFX_IDX;
        4'hF: sel_o = PS_GFX_DAT;
        default: sel_o = PS_NONE;
      endcase
    end else if ((in_mo || in_co) && !win_bad_o) begin
      case (lo)
        4'h4: sel_o = PS_CRT_IDX;
        4'h5: sel_o = PS_CRT_DAT;
        4'hA: sel_o = PS_STAT;
        default: sel_o = PS_NONE;
      endcase
    end
  end
endmodule

// File: rtl/disp_idx_file.sv
module disp_idx_file
  import disp_regport_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter bit IS_GFX = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic       dat_wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] idx_o,
  output logic [7:0] rdata_o
);
  localparam int N = 1 << IDX_W;

  logic [IDX_W-1:0] idx_q;
  logic [7:0]       ent_q [N];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       idx_q <= '0;
    else if (idx_wr_i) idx_q <= wdata_i[IDX_W-1:0];

  for (genvar k = 0; k < N; k++) begin : g_ent
    localparam logic [7:0] KEEP = IS_GFX ? gfx_keep(k) : seq_keep(k);
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) ent_q[k] <= '0;
      else if (dat_wr_i && idx_q == IDX_W'(k)) ent_q[k] <= wdata_i & KEEP;
  end

  assign idx_o   = 8'(idx_q);
  assign rdata_o = ent_q[idx_q];
endmodule

// File: rtl/disp_attr_port.sv
module disp_attr_port
  import disp_regport_pkg::*;
#(
  parameter int NREG = ATTR_N
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       clr_i,
  input  logic [7:0] wdata_i,
  output logic       ff_o,
  output logic [5:0] idx_o,
  output logic [7:0] rdata_o
);
  logic       ff_q;
  logic [5:0] idx_q;
  logic [7:0] ent_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ff_q  <= 1'b0;
      idx_q <= '0;
    end else if (clr_i) begin
      ff_q  <= 1'b0;
    end else if (wr_i) begin
      ff_q <= ~ff_q;
      if (!ff_q) idx_q <= wdata_i[5:0];
    end

  for (genvar k = 0; k < NREG; k++) begin : g_ent
    localparam logic [7:0] KEEP = attr_keep(k);
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) ent_q[k] <= '0;
      else if (wr_i && !clr_i && ff_q && idx_q[4:0] == 5'(k)) ent_q[k] <= wdata_i & KEEP;
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NREG; k++)
      if (idx_q[4:0] == 5'(k)) rdata_o = ent_q[k];
  end

  assign ff_o  = ff_q;
  assign idx_o = idx_q;

  p_ff_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !clr_i |=> ff_q != $past(ff_q));
  p_ff_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !ff_q);
  p_hi_idx_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(idx_q[4:0]) >= NREG) |-> rdata_o == 8'h00);
endmodule

// File: rtl/disp_crt_file.sv
module disp_crt_file
  import disp_regport_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int LOCK_IDX  = 8'h11,
  parameter int LOCK_LAST = 7,
  parameter int ID_LO     = 8'h2D,
  parameter int ID_HI     = 8'h30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idx_wr_i,
  input  logic             dat_wr_i,
  input  logic [7:0]       wdata_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [7:0]       rdata_o
);
  localparam int N = 1 << IDX_W;

  logic [IDX_W-1:0] idx_q;
  logic [7:0]       ent_q [N];
  logic             lock;

  assign lock = ent_q[LOCK_IDX][7];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       idx_q <= '0;
    else if (idx_wr_i) idx_q <= wdata_i[IDX_W-1:0];

  for (genvar k = 0; k < N; k++) begin : g_ent
    localparam logic [7:0] RV = crt_reset(k);
    logic hit;
    assign hit = dat_wr_i && idx_q == IDX_W'(k);
    if (k >= ID_LO && k <= ID_HI) begin : g_id
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ent_q[k] <= RV;
        else         ent_q[k] <= ent_q[k];
    end else if (k < LOCK_LAST) begin : g_low
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)          ent_q[k] <= RV;
        else if (hit && !lock) ent_q[k] <= wdata_i;
    end else if (k == LOCK_LAST) begin : g_last
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)  ent_q[k] <= RV;
        else if (hit) ent_q[k] <= lock ? {ent_q[k][7:5], wdata_i[4], ent_q[k][3:0]} : wdata_i;
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)  ent_q[k] <= RV;
        else if (hit) ent_q[k] <= wdata_i;
    end
  end

  assign idx_o   = idx_q;
  assign rdata_o = ent_q[idx_q];

  // packed view of the protected entries, bit 4 of the last one stays writable
  logic [8*(LOCK_LAST+1)-1:0] low_pack;
  always_comb
    for (int k = 0; k <= LOCK_LAST; k++) low_pack[8*k +: 8] = ent_q[k];
  localparam logic [8*(LOCK_LAST+1)-1:0] FREE_BIT = (8*(LOCK_LAST+1))'(1) << (8*LOCK_LAST+4);

  p_crt_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_wr_i && lock && int'(idx_q) <= LOCK_LAST |=> ((low_pack ^ $past(low_pack)) & ~FREE_BIT) == '0);
  p_id_const_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_wr_i |=> ent_q[ID_LO] == 8'h88 && ent_q[ID_HI] == 8'hE1);
endmodule

// File: rtl/disp_regport.sv
module disp_regport
  import disp_regport_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] MONO_BASE   = 16'h03B0,
  parameter logic [ADDR_W-1:0] COLOR_BASE  = 16'h03D0,
  parameter logic [ADDR_W-1:0] SHARED_BASE = 16'h03C0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam logic [7:0] ST_FLIP = 8'h09;

  port_sel_e  sel;
  logic       win_bad;
  logic [7:0] misc_q, fcr_q, st1_q;
  logic       attr_ff;
  logic [5:0] attr_idx;
  logic [7:0] attr_rd, seq_idx, seq_rd, gfx_idx, gfx_rd, crt_idx, crt_rd;

  disp_port_dec #(
    .ADDR_W(ADDR_W), .MONO_BASE(MONO_BASE), .COLOR_BASE(COLOR_BASE), .SHARED_BASE(SHARED_BASE)
  ) u_dec (
    .addr_i(addr_i), .color_i(misc_q[0]), .win_bad_o(win_bad), .sel_o(sel)
  );

  disp_attr_port u_attr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(wr_i && sel == PS_ATTR), .clr_i(rd_i && sel == PS_STAT),
    .wdata_i(wdata_i), .ff_o(attr_ff), .idx_o(attr_idx), .rdata_o(attr_rd)
  );

  disp_idx_file #(.IDX_W(3), .IS_GFX(1'b0)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .idx_wr_i(wr_i && sel == PS_SEQ_IDX), .dat_wr_i(wr_i && sel == PS_SEQ_DAT),
    .wdata_i(wdata_i), .idx_o(seq_idx), .rdata_o(seq_rd)
  );

  disp_idx_file #(.IDX_W(4), .IS_GFX(1'b1)) u_gfx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .idx_wr_i(wr_i && sel == PS_GFX_IDX), .dat_wr_i(wr_i && sel == PS_GFX_DAT),
    .wdata_i(wdata_i), .idx_o(gfx_idx), .rdata_o(gfx_rd)
  );

  disp_crt_file #(.IDX_W(8)) u_crt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .idx_wr_i(wr_i && sel == PS_CRT_IDX), .dat_wr_i(wr_i && sel == PS_CRT_DAT),
    .wdata_i(wdata_i), .idx_o(crt_idx), .rdata_o(crt_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      misc_q <= '0;
      fcr_q  <= '0;
      st1_q  <= '0;
    end else begin
      if (wr_i && sel == PS_MISC_ST0) misc_q <= wdata_i & 8'hEF;
      if (wr_i && sel == PS_STAT)     fcr_q  <= wdata_i & 8'h10;
      if (rd_i && sel == PS_STAT)     st1_q  <= st1_q ^ ST_FLIP;
    end

  always_comb begin
    if (win_bad) rdata_o = 8'hFF;
    else begin
      case (sel)
        PS_ATTR:     rdata_o = attr_ff ? 8'h00 : {2'b00, attr_idx};
        PS_ATTR_DAT: rdata_o = attr_rd;
        PS_SEQ_IDX:  rdata_o = seq_idx;
        PS_SEQ_DAT:  rdata_o = seq_rd;
        PS_GFX_IDX:  rdata_o = gfx_idx;
        PS_GFX_DAT:  rdata_o = gfx_rd;
        PS_CRT_IDX:  rdata_o = crt_idx;
        PS_CRT_DAT:  rdata_o = crt_rd;
        PS_FCR_RD:   rdata_o = fcr_q;
        PS_MISC_RD:  rdata_o = misc_q;
        PS_STAT:     rdata_o = st1_q ^ ST_FLIP;
        default:     rdata_o = 8'h00;
      endcase
    end
  end

  p_alias_ff_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && win_bad |-> rdata_o == 8'hFF);
  p_alias_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i || wr_i) && win_bad |=> $stable(st1_q) && $stable(fcr_q) && $stable(attr_ff));
  p_st_flip_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && sel == PS_STAT |=> st1_q == ($past(st1_q) ^ ST_FLIP));
endmodule

// File: tb/disp_regport_bench.sv
module disp_regport_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_regport u_disp_regport (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata)
  );

  // reference model
  logic [7:0] m_misc, m_fcr, m_st1, m_aidx, m_sidx, m_gidx, m_cidx;
  bit         m_ff;
  logic [7:0] m_attr [32];
  logic [7:0] m_seq [8];
  logic [7:0] m_gfx [16];
  logic [7:0] m_crt [256];
  logic [7:0] seq_k [8]  = '{8'h03, 8'h3D, 8'h0F, 8'h3F, 8'h0E, 8'h00, 8'h00, 8'hFF};
  logic [7:0] gfx_k [16] = '{8'h0F, 8'h0F, 8'h0F, 8'h1F, 8'h03, 8'h7B, 8'h0F, 8'h0F,
                             8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};

  task automatic m_reset();
    m_misc = 0; m_fcr = 0; m_st1 = 0; m_aidx = 0; m_sidx = 0; m_gidx = 0; m_cidx = 0; m_ff = 0;
    foreach (m_attr[i]) m_attr[i] = 0;
    foreach (m_seq[i]) m_seq[i] = 0;
    foreach (m_gfx[i]) m_gfx[i] = 0;
    foreach (m_crt[i]) m_crt[i] = 0;
    m_crt[8'h2D] = 8'h88; m_crt[8'h2E] = 8'hB0; m_crt[8'h2F] = 8'h01; m_crt[8'h30] = 8'hE1;
  endtask

  function automatic bit m_bad(input logic [15:0] a);
    return (a[15:4] == 12'h03B && m_misc[0]) || (a[15:4] == 12'h03D && !m_misc[0]);
  endfunction

  function automatic logic [7:0] m_rd(input logic [15:0] a);
    if (m_bad(a)) return 8'hFF;
    case (a)
      16'h3C0: return m_ff ? 8'h00 : m_aidx;
      16'h3C1: return (m_aidx[4:0] < 21) ? m_attr[m_aidx[4:0]] : 8'h00;
      16'h3C4: return m_sidx;
      16'h3C5: return m_seq[m_sidx[2:0]];
      16'h3CA: return m_fcr;
      16'h3CC: return m_misc;
      16'h3CE: return m_gidx;
      16'h3CF: return m_gfx[m_gidx[3:0]];
      16'h3B4, 16'h3D4: return m_cidx;
      16'h3B5, 16'h3D5: return m_crt[m_cidx];
      16'h3BA, 16'h3DA: return m_st1 ^ 8'h09;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_rd_side(input logic [15:0] a);
    if (!m_bad(a) && (a == 16'h3BA || a == 16'h3DA)) begin
      m_st1 ^= 8'h09; m_ff = 0;
    end
  endtask

  task automatic m_wr(input logic [15:0] a, input logic [7:0] d);
    int i;
    if (m_bad(a)) return;
    case (a)
      16'h3C0: begin
        if (!m_ff) m_aidx = d & 8'h3F;
        else begin
          i = m_aidx[4:0];
          if (i < 16) m_attr[i] = d & 8'h3F;
          else if (i == 16) m_attr[i] = d & 8'hEF;
          else if (i == 17) m_attr[i] = d;
          else if (i == 18) m_attr[i] = d & 8'h3F;
          else if (i < 21) m_attr[i] = d & 8'h0F;
        end
        m_ff = !m_ff;
      end
      16'h3C2: m_misc = d & 8'hEF;
      16'h3C4: m_sidx = d & 8'h07;
      16'h3C5: m_seq[m_sidx[2:0]] = d & seq_k[m_sidx[2:0]];
      16'h3CE: m_gidx = d & 8'h0F;
      16'h3CF: m_gfx[m_gidx[3:0]] = d & gfx_k[m_gidx[3:0]];
      16'h3B4, 16'h3D4: m_cidx = d;
      16'h3B5, 16'h3D5: begin
        if (m_crt[8'h11][7] && m_cidx <= 7) begin
          if (m_cidx == 7) m_crt[7] = (m_crt[7] & 8'hEF) | (d & 8'h10);
        end else if (!(m_cidx >= 8'h2D && m_cidx <= 8'h30)) m_crt[m_cidx] = d;
      end
      16'h3BA, 16'h3DA: m_fcr = d & 8'h10;
      default: ;
    endcase
  endtask

  function automatic string tag_of(input logic [15:0] a);
    if (m_bad(a)) return "R2";
    case (a)
      16'h3C0: return "R3";
      16'h3C1: return "R4";
      16'h3C4, 16'h3C5, 16'h3CE, 16'h3CF: return "R6";
      16'h3B4, 16'h3D4, 16'h3B5, 16'h3D5: return "R7";
      16'h3BA, 16'h3DA: return "R8";
      16'h3C2, 16'h3CA, 16'h3CC: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1; rd = 1'b0;
    m_wr(a, d);
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic do_rd(input logic [15:0] a, input string tag);
    @(negedge clk);
    addr = a; rd = 1'b1; wr = 1'b0;
    #1;
    check(tag, rdata, m_rd(a));
    m_rd_side(a);
    @(posedge clk); #1;
    rd = 1'b0;
  endtask

  task automatic crt_set(input logic [15:0] base, input logic [7:0] i, input logic [7:0] d);
    do_wr(base + 16'h4, i);
    do_wr(base + 16'h5, d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  logic [15:0] plist [19] = '{16'h3C0, 16'h3C1, 16'h3C2, 16'h3C4, 16'h3C5, 16'h3CA, 16'h3CC,
                              16'h3CE, 16'h3CF, 16'h3B4, 16'h3B5, 16'h3BA, 16'h3D4, 16'h3D5,
                              16'h3DA, 16'h3C7, 16'h3C3, 16'h3B0, 16'h3DF};

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset values, mono window live
    do_rd(16'h3CC, "R1");
    do_rd(16'h3CA, "R1");
    do_rd(16'h3C0, "R1");
    for (int i = 0; i < 8; i++) begin do_wr(16'h3C4, 8'(i)); do_rd(16'h3C5, "R1"); end
    for (int i = 0; i < 16; i++) begin do_wr(16'h3CE, 8'(i)); do_rd(16'h3CF, "R1"); end
    for (int i = 8'h2C; i <= 8'h31; i++) begin do_wr(16'h3B4, 8'(i)); do_rd(16'h3B5, "R1"); end

    // R2: colour window dead while bit 0 clear
    do_rd(16'h3D5, "R2");
    do_rd(16'h3DA, "R2");
    do_rd(16'h3C0, "R2");

    // R3/R4: index store, data to index >= 21 dropped, ff phase
    do_wr(16'h3C0, 8'hFF);
    do_rd(16'h3C0, "R4");
    do_rd(16'h3C1, "R4");
    do_wr(16'h3C0, 8'h55);
    do_rd(16'h3C0, "R3");

    // R5: masks at entry boundaries
    for (int i = 14; i < 24; i++) begin
      do_wr(16'h3C0, 8'(i));
      do_wr(16'h3C0, 8'hFF);
      do_rd(16'h3C1, "R5");
    end

    // R8: status read clears ff mid-pair
    do_wr(16'h3C0, 8'h10);
    do_rd(16'h3BA, "R8");
    do_rd(16'h3BA, "R8");
    do_rd(16'h3C0, "R8");

    // R9
    do_wr(16'h3C2, 8'hFE);
    do_rd(16'h3CC, "R9");
    do_rd(16'h3C2, "R9");
    do_wr(16'h3C2, 8'h00);
    do_wr(16'h3BA, 8'hFF);
    do_rd(16'h3CA, "R9");

    // R10 / R11
    crt_set(16'h3B0, 8'h2E, 8'h00);
    do_rd(16'h3B5, "R10");
    crt_set(16'h3B0, 8'hFF, 8'hA5);
    do_rd(16'h3B4, "R11");
    do_rd(16'h3B5, "R11");
    do_rd(16'h3C7, "R11");

    // R7: lock, switch to colour window
    do_wr(16'h3C2, 8'h01);
    crt_set(16'h3D0, 8'h03, 8'h5A);
    crt_set(16'h3D0, 8'h07, 8'hC3);
    crt_set(16'h3D0, 8'h11, 8'h80);
    crt_set(16'h3D0, 8'h03, 8'hFF);
    do_rd(16'h3D5, "R7");
    crt_set(16'h3D0, 8'h07, 8'h3C);
    do_rd(16'h3D5, "R7");
    crt_set(16'h3D0, 8'h08, 8'h77);
    do_rd(16'h3D5, "R7");
    do_rd(16'h3B5, "R2");
    crt_set(16'h3D0, 8'h11, 8'h00);
    crt_set(16'h3D0, 8'h03, 8'h11);
    do_rd(16'h3D5, "R7");

    // mixed random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] a;
      logic [7:0]  d;
      a = plist[$urandom_range(0, 18)];
      d = 8'($urandom);
      if (a == 16'h3C2 && $urandom_range(0, 3) != 0) d[0] = m_misc[0];
      if ($urandom_range(0, 1) == 0) do_wr(a, d);
      else do_rd(a, tag_of(a));
    end

    finish_run();
  end
endmodule